// File: doc/BRIEF.md
# Daisy-chain DAC command driver

This block feeds 12-bit sample values to two serial DACs that share one three-wire link (serial clock, frame strobe, serial data) with the devices wired in series. On each accepted request it assembles one 16-bit command word per device and clocks all of them out back to back inside a single low period of the frame strobe. The far device's word goes out first, so it travels through the near device's shift register. A per-device enable picks the control code for each word. An enabled device gets the load-and-update code. A disabled device gets the no-op code, so its analog output stays where it was.

Samples come either from the `data_i` port or from an internal ramp counter. A simple ready/start handshake accepts a new request only while the engine is idle. `done_o` marks the cycle in which the strobe returns high after the last bit. The serial clock is divided down from the system clock; the default divider gives 20 MHz from a 200 MHz system clock.

Top module: `dac_chain_driver`

## Requirements
- R1: Each device word is 16 bits wide, with the control code in bits [15:12] and the sample in bits [11:0]. Words are shifted MSB first.
- R2: When `upd_en_i[k]` is 1, device k's word carries control code 4'b0001, which loads the sample and updates the output. When it is 0, the word carries 4'b0000, a no-op, and that device's output does not change.
- R3: Each frame shifts exactly 32 bits (32 falling SCLK edges) while SYNC stays low. Device 1 is the far device and uses `data_i[23:12]` and `upd_en_i[1]`; its word is sent first. Device 0 is the near device and uses `data_i[11:0]` and `upd_en_i[0]`; its word is sent last.
- R4: Before SYNC falls it stays high for at least two SCLK periods. Whenever SYNC is high, SDIN is low and SCLK is at its idle level of 1.
- R5: SDIN changes only together with a rising SCLK edge or a SYNC fall. It is stable at every falling SCLK edge, which is where the devices sample.
- R6: Every SCLK level and the gap from the SYNC fall to the first SCLK edge last `SCLK_HALF_DIV` system clocks. The default of 5 gives 20 MHz at 200 MHz.
- R7: `ready_o` is high only when the engine is idle. A request (`start_i` with `ready_o`) is accepted and `ready_o` drops on the next cycle. A `start_i` raised while the engine is busy is ignored.
- R8: `done_o` is a one-cycle pulse. It is high exactly in the cycle in which SYNC rises after the 32nd bit and in no other cycle.
- R9: When `ramp_mode_i` is 1 at acceptance, every device's sample equals the ramp value. The ramp is 0 after reset, increases by one per completed frame and wraps from 4095 to 0.
- R10: Reset drives SYNC high, SCLK high, SDIN low, `done_o` low and `ready_o` high, and clears the ramp to zero. This also holds when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one frame |
| ready_o | output | 1 | Engine idle, request can be accepted |
| data_i | input | 24 | Samples: [23:12] for the far device, [11:0] for the near device |
| upd_en_i | input | 2 | Per-device update enable: [1] far, [0] near |
| ramp_mode_i | input | 1 | Use the internal ramp instead of data_i |
| sclk_o | output | 1 | Serial clock, idles high |
| sync_o | output | 1 | Frame strobe, active low |
| sdin_o | output | 1 | Serial data to the first device |
| done_o | output | 1 | Pulse when a frame ends |

## Verification
The assertions take for granted that `data_i`, `upd_en_i` and `ramp_mode_i` matter only in the cycle a request is accepted. They also assume `start_i` may arrive at any time, busy or not. The bench changes inputs only at the falling system-clock edge and holds `start_i` for one cycle per request. One stimulus pulses `start_i` in the middle of a frame with different data, and another applies reset part-way through a frame. Neither of these stimuli ever sends more than one request per idle period.

// File: rtl/dac_chain_pkg.sv
`timescale 1ns/1ps
package dac_chain_pkg;
  localparam int WORD_W = 16;
  localparam int CTRL_W = 4;
  localparam int DATA_W = 12;
  localparam logic [CTRL_W-1:0] CTRL_LOAD = 4'b0001;
  localparam logic [CTRL_W-1:0] CTRL_NOP  = 4'b0000;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SHIFT} eng_state_e;
endpackage

// File: rtl/dac_sclk_div.sv
`timescale 1ns/1ps
module dac_sclk_div #(
  parameter int unsigned HALF_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r6_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/dac_ramp_src.sv
`timescale 1ns/1ps
module dac_ramp_src
  import dac_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [DATA_W-1:0] ramp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ramp_o <= '0;
    else if (adv_i) ramp_o <= ramp_o + 1'b1;  // wraps at full scale
  end

  a_r9_ramp_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ramp_o == DATA_W'($past(ramp_o) + 1'b1));
  a_r9_ramp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ramp_o));
endmodule

// File: rtl/dac_frame_build.sv
`timescale 1ns/1ps
module dac_frame_build
  import dac_chain_pkg::*;
#(
  parameter int N_DEV = 2,
  localparam int FRAME_W = N_DEV * WORD_W
) (
  input  logic [N_DEV*DATA_W-1:0] data_i,
  input  logic [N_DEV-1:0]        upd_en_i,
  input  logic                    ramp_mode_i,
  input  logic [DATA_W-1:0]       ramp_i,
  output logic [FRAME_W-1:0]      frame_o
);
  // device k occupies word k; the highest word leaves first and reaches the far end
  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    logic [DATA_W-1:0] samp;
    assign samp = ramp_mode_i ? ramp_i : data_i[k*DATA_W +: DATA_W];
    assign frame_o[k*WORD_W +: WORD_W] = {(upd_en_i[k] ? CTRL_LOAD : CTRL_NOP), samp};
  end
endmodule

// File: rtl/dac_shift_eng.sv
`timescale 1ns/1ps
module dac_shift_eng
  import dac_chain_pkg::*;
#(
  parameter int FRAME_W   = 32,
  parameter int PRE_TICKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  output logic               ready_o,
  output logic               busy_o,
  output logic               sclk_o,
  output logic               sync_o,
  output logic               sdin_o,
  output logic               done_o
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam int PW = (PRE_TICKS > 1) ? $clog2(PRE_TICKS) : 1;

  eng_state_e         state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BW-1:0]      bit_q;
  logic [PW-1:0]      pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      pre_q   <= '0;
      sclk_o  <= 1'b1;
      sync_o  <= 1'b1;
      sdin_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sh_q    <= frame_i;
          pre_q   <= '0;
          state_q <= ST_PRE;
        end
        ST_PRE: if (tick_i) begin
          if (pre_q == PW'(PRE_TICKS - 1)) begin
            state_q <= ST_SHIFT;
            sync_o  <= 1'b0;
            sdin_o  <= sh_q[FRAME_W-1];
            bit_q   <= '0;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        ST_SHIFT: if (tick_i) begin
          if (sclk_o) begin
            sclk_o <= 1'b0;  // devices sample here
          end else begin
            sclk_o <= 1'b1;  // data moves on the opposite edge
            if (bit_q == BW'(FRAME_W - 1)) begin
              state_q <= ST_IDLE;
              sync_o  <= 1'b1;
              sdin_o  <= 1'b0;
              done_o  <= 1'b1;
            end else begin
              bit_q  <= bit_q + 1'b1;
              sh_q   <= sh_q << 1;
              sdin_o <= sh_q[FRAME_W-2];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = !ready_o;

  a_r4_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> (!sdin_o && sclk_o));
  a_r5_sdin_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(sdin_o));
  a_r8_done_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(sync_o));
  a_r8_rise_has_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> done_o);
  a_r7_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);
  a_r3_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q < BW'(FRAME_W));
  a_r3_sync_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_o |-> busy_o);
endmodule

// File: rtl/dac_chain_driver.sv
`timescale 1ns/1ps
module dac_chain_driver
  import dac_chain_pkg::*;
#(
  parameter int N_DEV            = 2,
  parameter int SCLK_HALF_DIV    = 5,
  parameter int PRE_SCLK_PERIODS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  output logic                    ready_o,
  input  logic [N_DEV*DATA_W-1:0] data_i,
  input  logic [N_DEV-1:0]        upd_en_i,
  input  logic                    ramp_mode_i,
  output logic                    sclk_o,
  output logic                    sync_o,
  output logic                    sdin_o,
  output logic                    done_o
);
  localparam int FRAME_W   = N_DEV * WORD_W;
  localparam int PRE_TICKS = 2 * PRE_SCLK_PERIODS;

  logic               tick;
  logic               busy;
  logic [DATA_W-1:0]  ramp;
  logic [FRAME_W-1:0] frame;

  dac_sclk_div #(.HALF_DIV(SCLK_HALF_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .tick_o(tick)
  );

  dac_ramp_src u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(done_o), .ramp_o(ramp)
  );

  dac_frame_build #(.N_DEV(N_DEV)) u_build (
    .data_i(data_i), .upd_en_i(upd_en_i), .ramp_mode_i(ramp_mode_i),
    .ramp_i(ramp), .frame_o(frame)
  );

  dac_shift_eng #(.FRAME_W(FRAME_W), .PRE_TICKS(PRE_TICKS)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .frame_i(frame),
    .tick_i(tick), .ready_o(ready_o), .busy_o(busy), .sclk_o(sclk_o),
    .sync_o(sync_o), .sdin_o(sdin_o), .done_o(done_o)
  );
endmodule

// File: tb/dac_chain_driver_bench.sv
`timescale 1ns/1ps
module dac_chain_driver_bench;
  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] data = '0;
  logic [1:0]  upd_en = '0;
  logic        ramp_mode = 1'b0;
  logic        ready, sclk, sync, sdin, done;

  always #2.5 clk = ~clk;

  dac_chain_driver u_dac_chain_driver (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_o(ready),
    .data_i(data), .upd_en_i(upd_en), .ramp_mode_i(ramp_mode),
    .sclk_o(sclk), .sync_o(sync), .sdin_o(sdin), .done_o(done)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model of two chained 16-bit device registers
  logic [15:0] far_sr = '0, near_sr = '0;
  logic [11:0] far_out = '0, near_out = '0;
  logic [11:0] exp_far = '0, exp_near = '0;
  int bits = 0, frames = 0, hi_cnt = 0, ev_cnt = 0;
  logic p_sclk = 1'b1, p_sync = 1'b1, p_sdin = 1'b0;
  bit mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      ev_cnt++;
      if (sync) begin
        hi_cnt++;
        if (sdin !== 1'b0 || sclk !== 1'b1)
          chk(1'b0, "R4", "sdin/sclk while sync high", {sdin, sclk}, 1);
      end
      if (sync && !p_sync) begin
        chk(bits == 32, "R3", "bits per frame", bits, 32);
        chk(done === 1'b1, "R8", "done at sync rise", done, 1);
        chk(ev_cnt == HALF, "R6", "last half period", ev_cnt, HALF);
        if (far_sr[15:12] == 4'b0001) far_out = far_sr[11:0];
        if (near_sr[15:12] == 4'b0001) near_out = near_sr[11:0];
        frames++;
        hi_cnt = 1;
      end else if (!sync && p_sync) begin
        chk(hi_cnt >= 4 * HALF, "R4", "sync high before frame", hi_cnt, 4 * HALF);
        bits = 0;
        ev_cnt = 0;
      end else begin
        if (done === 1'b1) chk(1'b0, "R8", "done without sync rise", 1, 0);
        if (!sync && sclk != p_sclk) begin
          chk(ev_cnt == HALF, "R6", "sclk half period", ev_cnt, HALF);
          ev_cnt = 0;
          if (!sclk) begin
            chk(sdin == p_sdin, "R5", "sdin stable at falling edge", sdin, p_sdin);
            far_sr  = {far_sr[14:0], near_sr[15]};
            near_sr = {near_sr[14:0], sdin};
            bits++;
          end
        end else if (!sync && sdin != p_sdin) begin
          chk(1'b0, "R5", "sdin changed without rising sclk", sdin, p_sdin);
        end
      end
    end
    p_sclk = sclk;
    p_sync = sync;
    p_sdin = sdin;
  end

  task automatic do_reset();
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(sync === 1'b1, "R10", "sync in reset", sync, 1);
    chk(sclk === 1'b1, "R10", "sclk in reset", sclk, 1);
    chk(sdin === 1'b0 && done === 1'b0, "R10", "sdin/done in reset", {sdin, done}, 0);
    chk(ready === 1'b1, "R10", "ready in reset", ready, 1);
    rst_n = 1'b1;
    frames = 0;
    bits = 0;
    hi_cnt = 0;
    @(negedge clk);
    mon_on = 1'b1;
  endtask

  task automatic send(input logic [11:0] dfar, input logic [11:0] dnear,
                      input logic [1:0] en, input bit use_ramp, input bit poke);
    int f0;
    int guard;
    logic [11:0] vfar, vnear;
    f0 = frames;
    vfar  = use_ramp ? 12'(frames) : dfar;
    vnear = use_ramp ? 12'(frames) : dnear;
    @(negedge clk);
    chk(ready === 1'b1, "R7", "ready before request", ready, 1);
    start = 1'b1; data = {dfar, dnear}; upd_en = en; ramp_mode = use_ramp;
    @(negedge clk);
    start = 1'b0;
    chk(ready === 1'b0, "R7", "ready after accept", ready, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; data = ~{dfar, dnear}; upd_en = ~en; ramp_mode = ~use_ramp;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (frames == f0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(frames == f0 + 1, "R3", "frame completed", frames, f0 + 1);
    chk(far_sr[15:12] == {3'b000, en[1]}, "R2", "far control code", far_sr[15:12], en[1]);
    chk(near_sr[15:12] == {3'b000, en[0]}, "R2", "near control code", near_sr[15:12], en[0]);
    chk(far_sr[11:0] == vfar, use_ramp ? "R9" : "R1", "far data field", far_sr[11:0], vfar);
    chk(near_sr[11:0] == vnear, use_ramp ? "R9" : "R1", "near data field", near_sr[11:0], vnear);
    if (en[1]) exp_far = vfar;
    if (en[0]) exp_near = vnear;
    chk(far_out == exp_far, "R2", "far device output", far_out, exp_far);
    chk(near_out == exp_near, "R2", "near device output", near_out, exp_near);
    if (poke) begin
      repeat (400) @(negedge clk);
      chk(frames == f0 + 1 && ready === 1'b1, "R7", "busy start ignored", frames, f0 + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R9: ramp starts at zero and steps per frame
    send(12'h000, 12'h000, 2'b11, 1'b1, 1'b0);
    send(12'h000, 12'h000, 2'b11, 1'b1, 1'b0);
    send(12'h000, 12'h000, 2'b10, 1'b1, 1'b0);
    // R1/R3: distinct far and near samples, both updated
    send(12'hABC, 12'h123, 2'b11, 1'b0, 1'b0);
    // R2: only far, only near, neither
    send(12'h555, 12'hAAA, 2'b10, 1'b0, 1'b0);
    send(12'hFFF, 12'h001, 2'b01, 1'b0, 1'b0);
    send(12'h0F0, 12'hF0F, 2'b00, 1'b0, 1'b0);
    send(12'h800, 12'h7FF, 2'b11, 1'b0, 1'b0);
    // R7: start raised mid-frame is ignored
    send(12'h3C7, 12'hC78, 2'b11, 1'b0, 1'b1);
    // R9: ramp continues after external frames
    send(12'h000, 12'h000, 2'b01, 1'b1, 1'b0);
    // R10: reset in the middle of a frame, then ramp back at zero
    @(negedge clk);
    start = 1'b1; data = 24'h5A5A5A; upd_en = 2'b11; ramp_mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);
    do_reset();
    send(12'h000, 12'h000, 2'b11, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule